// File: doc/BRIEF.md
# Monitor Value Readout with Alarm Thresholds

This block keeps the latest 16-bit reading for each of a fixed set of monitored items, such as temperature, supply voltage, per-channel bias or optical power, and elapsed time. Samples arrive on a valid/ready stream that carries an item index and a value. Software reads each value as two bytes over a byte-wide register port, most significant byte first. The first byte read of an item copies the whole value into a shadow register. The second byte then comes from that copy, so a two-byte read never mixes old and new samples, even while samples keep arriving.

Each item has a programmable upper and lower alarm limit. Both limits are held as byte pairs, most significant byte first, and are written and read through the same register port. Every accepted sample is compared against the limits of its item. When a limit is passed, the block drives a one-cycle event on a per-item output, and a separate flag block latches and masks these events. A data-available output goes high once every item has been sampled at least once after reset.

Stream rules: `smp_ready` is low while reset is held and high from the first clock edge after reset. A sample is taken on any rising edge where `smp_valid` and `smp_ready` are both high. A sample whose index is `NUM_ITEMS` or more is accepted and then discarded. The block never applies back-pressure in normal operation, so a producer may hold `smp_valid` high and present a new sample every cycle.

Top module: `mon_readout`

## Requirements
- R1: `smp_ready` is 0 during reset and 1 from the first clock after reset. A sample with `smp_valid` and `smp_ready` both high replaces the stored value of item `smp_idx`.
- R2: The value of item i is read at byte address 2i (bits 15:8) and 2i+1 (bits 7:0). `reg_rdata` shows the byte in the cycle after the rising edge where `reg_rd` is high.
- R3: A read of address 2i copies item i's full value into a shadow register. A later read of any odd value address returns the shadow's bits 7:0, even if new samples have arrived in between.
- R4: Upper limit of item i sits at addresses 2N+2i (bits 15:8) and 2N+2i+1 (bits 7:0). Lower limit sits at 4N+2i and 4N+2i+1, where N is `NUM_ITEMS`. These bytes are written with `reg_wr` and `reg_wdata` and read back unchanged.
- R5: After reset, all values read as 0x0000, every upper limit reads as 0xFFFF and every lower limit reads as 0x0000.
- R6: In the cycle after a sample for item i is accepted, `alarm_hi[i]` is high for one cycle if the sample is strictly greater than the upper limit. A sample equal to the limit raises nothing.
- R7: In the cycle after a sample for item i is accepted, `alarm_lo[i]` is high for one cycle if the sample is strictly less than the lower limit. A sample equal to the limit raises nothing.
- R8: `data_avail` is 0 after reset. It rises in the cycle after every item has had at least one sample accepted, and it stays high until the next reset.
- R9: Writes to value addresses or to addresses 6N and above change nothing. Reads of addresses 6N and above return 0x00.
- R10: `reg_rdata` keeps its value in every cycle that follows an edge with `reg_rd` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| smp_idx | input | IW | Item index of the sample |
| smp_data | input | 16 | Sample value |
| reg_addr | input | AW | Register byte address |
| reg_wr | input | 1 | Write strobe for limit bytes |
| reg_wdata | input | 8 | Write data byte |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data byte, registered |
| data_avail | output | 1 | All items have been sampled at least once |
| alarm_hi | output | NUM_ITEMS | Per-item upper-limit event pulse |
| alarm_lo | output | NUM_ITEMS | Per-item lower-limit event pulse |

## Verification
The bench changes an item's value between its high-byte read and its low-byte read. A design without a working snapshot would return the low byte of the new sample instead of the old one. It drives samples exactly equal to each limit and one count past it, which catches a comparison that uses the wrong inequality or reacts to the equal value. It checks that `data_avail` stays low until the last remaining item is sampled and then stays high; an early or level-following indication fails that check. It also writes into the value region and reads out-of-range addresses, which exposes a decoder that overlaps regions.

// File: rtl/mon_pkg.sv
package mon_pkg;
  localparam int VAL_W  = 16;
  localparam int BYTE_W = 8;

  typedef logic [VAL_W-1:0]  mon_val_t;
  typedef logic [BYTE_W-1:0] mon_byte_t;

  // byte k of a big-endian pair: k=0 is the upper byte
  function automatic mon_byte_t pick_byte(input mon_val_t v, input logic lsb);
    return lsb ? v[7:0] : v[15:8];
  endfunction
endpackage

// File: rtl/mon_sample_store.sv
module mon_sample_store
  import mon_pkg::*;
#(
  parameter int NUM_ITEMS = 8,
  parameter int IW        = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_i,
  input  logic [IW-1:0]              idx_i,
  input  mon_val_t                   data_i,
  output logic                       ready_o,
  output logic [NUM_ITEMS*VAL_W-1:0] vals_o,
  output logic                       avail_o
);
  mon_val_t              val_q [NUM_ITEMS];
  logic [NUM_ITEMS-1:0]  seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_o <= 1'b0;
      avail_o <= 1'b0;
      seen_q  <= '0;
    end else begin
      ready_o <= 1'b1;
      if (acc_i && (int'(idx_i) < NUM_ITEMS)) seen_q[idx_i] <= 1'b1;
      if (&seen_q) avail_o <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_ITEMS; g++) begin : g_item
    always_ff @(posedge clk) begin
      if (!rst_n)                                val_q[g] <= '0;
      else if (acc_i && (int'(idx_i) == g))      val_q[g] <= data_i;
    end
    assign vals_o[g*VAL_W +: VAL_W] = val_q[g];
  end

  AST_AVAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    avail_o |=> avail_o); // R8
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o); // R1
endmodule

// File: rtl/mon_thresh_bank.sv
module mon_thresh_bank
  import mon_pkg::*;
#(
  parameter int NUM_ITEMS = 8,
  parameter int IW        = 3,
  parameter int AW        = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [AW-1:0]              addr_i,
  input  mon_byte_t                  wdata_i,
  input  logic                       acc_i,
  input  logic [IW-1:0]              idx_i,
  input  mon_val_t                   data_i,
  output logic [NUM_ITEMS*VAL_W-1:0] hi_o,
  output logic [NUM_ITEMS*VAL_W-1:0] lo_o,
  output logic [NUM_ITEMS-1:0]       alarm_hi_o,
  output logic [NUM_ITEMS-1:0]       alarm_lo_o
);
  localparam int HI_BASE = 2 * NUM_ITEMS;
  localparam int LO_BASE = 4 * NUM_ITEMS;
  localparam int END_A   = 6 * NUM_ITEMS;

  mon_val_t hi_q [NUM_ITEMS];
  mon_val_t lo_q [NUM_ITEMS];

  for (genvar g = 0; g < NUM_ITEMS; g++) begin : g_lim
    localparam int HA = HI_BASE + 2 * g;
    localparam int LA = LO_BASE + 2 * g;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q[g] <= '1;
        lo_q[g] <= '0;
      end else if (wr_i) begin
        if (int'(addr_i) == HA)     hi_q[g][15:8] <= wdata_i;
        if (int'(addr_i) == HA + 1) hi_q[g][7:0]  <= wdata_i;
        if (int'(addr_i) == LA)     lo_q[g][15:8] <= wdata_i;
        if (int'(addr_i) == LA + 1) lo_q[g][7:0]  <= wdata_i;
      end
    end
    assign hi_o[g*VAL_W +: VAL_W] = hi_q[g];
    assign lo_o[g*VAL_W +: VAL_W] = lo_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alarm_hi_o[g] <= 1'b0;
        alarm_lo_o[g] <= 1'b0;
      end else begin
        alarm_hi_o[g] <= acc_i && (int'(idx_i) == g) && (data_i > hi_q[g]);
        alarm_lo_o[g] <= acc_i && (int'(idx_i) == g) && (data_i < lo_q[g]);
      end
    end
  end

  logic unused_end;
  assign unused_end = (END_A > 0);

  AST_ALARM_ONE_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alarm_hi_o | alarm_lo_o)); // R6
  AST_ALARM_HAS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(alarm_hi_o | alarm_lo_o)) |-> $past(acc_i)); // R7
endmodule

// File: rtl/mon_read_mux.sv
module mon_read_mux
  import mon_pkg::*;
#(
  parameter int NUM_ITEMS = 8,
  parameter int AW        = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [NUM_ITEMS*VAL_W-1:0] vals_i,
  input  logic [NUM_ITEMS*VAL_W-1:0] hi_i,
  input  logic [NUM_ITEMS*VAL_W-1:0] lo_i,
  output mon_byte_t                  rdata_o
);
  localparam int HI_BASE = 2 * NUM_ITEMS;
  localparam int LO_BASE = 4 * NUM_ITEMS;
  localparam int END_A   = 6 * NUM_ITEMS;

  mon_val_t  shadow_q;
  mon_val_t  sel_val;
  mon_byte_t next_byte;
  logic      val_msb;
  int        a;
  int        item;

  always_comb begin
    a         = int'(addr_i);
    item      = 0;
    sel_val   = '0;
    next_byte = '0;
    val_msb   = 1'b0;
    if (a < HI_BASE) begin
      item    = a / 2;
      sel_val = vals_i[item*VAL_W +: VAL_W];
      val_msb = !addr_i[0];
      next_byte = addr_i[0] ? shadow_q[7:0] : sel_val[15:8];
    end else if (a < LO_BASE) begin
      item      = (a - HI_BASE) / 2;
      next_byte = pick_byte(hi_i[item*VAL_W +: VAL_W], addr_i[0]);
    end else if (a < END_A) begin
      item      = (a - LO_BASE) / 2;
      next_byte = pick_byte(lo_i[item*VAL_W +: VAL_W], addr_i[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      shadow_q <= '0;
    end else if (rd_i) begin
      rdata_o <= next_byte;
      if (val_msb) shadow_q <= sel_val;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_i) |-> $stable(rdata_o)); // R10
  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_i && val_msb) |-> $stable(shadow_q)); // R3
endmodule

// File: rtl/mon_readout.sv
module mon_readout
  import mon_pkg::*;
#(
  parameter int NUM_ITEMS = 8,
  parameter int IW        = $clog2(NUM_ITEMS),
  parameter int AW        = $clog2(6 * NUM_ITEMS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [IW-1:0]        smp_idx,
  input  logic [15:0]          smp_data,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_wdata,
  input  logic                 reg_rd,
  output logic [7:0]           reg_rdata,
  output logic                 data_avail,
  output logic [NUM_ITEMS-1:0] alarm_hi,
  output logic [NUM_ITEMS-1:0] alarm_lo
);
  logic                       acc;
  logic [NUM_ITEMS*VAL_W-1:0] vals;
  logic [NUM_ITEMS*VAL_W-1:0] hi_lim;
  logic [NUM_ITEMS*VAL_W-1:0] lo_lim;

  assign acc = smp_valid && smp_ready;

  mon_sample_store #(.NUM_ITEMS(NUM_ITEMS), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .idx_i(smp_idx), .data_i(smp_data),
    .ready_o(smp_ready), .vals_o(vals), .avail_o(data_avail)
  );

  mon_thresh_bank #(.NUM_ITEMS(NUM_ITEMS), .IW(IW), .AW(AW)) u_lim (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .acc_i(acc), .idx_i(smp_idx), .data_i(smp_data),
    .hi_o(hi_lim), .lo_o(lo_lim), .alarm_hi_o(alarm_hi), .alarm_lo_o(alarm_lo)
  );

  mon_read_mux #(.NUM_ITEMS(NUM_ITEMS), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_i(reg_rd), .addr_i(reg_addr),
    .vals_i(vals), .hi_i(hi_lim), .lo_i(lo_lim), .rdata_o(reg_rdata)
  );

  AST_NO_ALARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc) |-> (alarm_hi == '0 && alarm_lo == '0)); // R6
endmodule

// File: tb/mon_readout_bench.sv
module mon_readout_bench;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [IW-1:0] smp_idx = '0;
  logic [15:0]   smp_data = '0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [7:0]    reg_rdata;
  logic          data_avail;
  logic [N-1:0]  alarm_hi, alarm_lo;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mon_readout #(.NUM_ITEMS(N)) u_mon_readout (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_idx(smp_idx), .smp_data(smp_data), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .data_avail(data_avail), .alarm_hi(alarm_hi), .alarm_lo(alarm_lo)
  );

  // op: 0 write byte, 1 read byte, 2 sample (addr = item index)
  // exp: read -> byte; sample -> {lo_event, hi_event}
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [17] = '{
    '{2'd0, 8'd20, 16'h0012, 16'h0000}, // R4 upper limit item 2, high byte
    '{2'd0, 8'd21, 16'h0034, 16'h0000}, // R4
    '{2'd0, 8'd36, 16'h0001, 16'h0000}, // R4 lower limit item 2
    '{2'd0, 8'd37, 16'h0000, 16'h0000}, // R4
    '{2'd1, 8'd20, 16'h0000, 16'h0012}, // R4 read back
    '{2'd1, 8'd21, 16'h0000, 16'h0034}, // R4
    '{2'd1, 8'd36, 16'h0000, 16'h0001}, // R4
    '{2'd2, 8'd2,  16'h1235, 16'h0001}, // R6 one above upper
    '{2'd2, 8'd2,  16'h1234, 16'h0000}, // R6 equal to upper
    '{2'd2, 8'd2,  16'h00FF, 16'h0002}, // R7 one below lower
    '{2'd2, 8'd2,  16'h0100, 16'h0000}, // R7 equal to lower
    '{2'd1, 8'd4,  16'h0000, 16'h0001}, // R2 high byte item 2
    '{2'd1, 8'd5,  16'h0000, 16'h0000}, // R2 low byte item 2
    '{2'd2, 8'd5,  16'hFFFF, 16'h0000}, // R6 equal to default upper
    '{2'd1, 8'd10, 16'h0000, 16'h00FF}, // R1 stored item 5
    '{2'd1, 8'd11, 16'h0000, 16'h00FF}, // R1
    '{2'd2, 8'd0,  16'h0000, 16'h0000}  // R7 equal to default lower
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] addr, input logic [15:0] data);
    @(negedge clk);
    reg_wr = (op == 2'd0); reg_rd = (op == 2'd1);
    reg_addr = addr[AW-1:0]; reg_wdata = data[7:0];
    smp_valid = (op == 2'd2); smp_idx = addr[IW-1:0]; smp_data = data;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; smp_valid = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] addr, input logic [7:0] expv);
    do_op(2'd1, addr, 16'h0);
    check(req, {24'h0, reg_rdata}, {24'h0, expv});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'h0, smp_ready}, 32'h0);
    check("R8 avail in reset", {31'h0, data_avail}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'h0, smp_ready}, 32'h1);
    check("R6 R7 no alarm after reset", {16'h0, alarm_hi, alarm_lo}, 32'h0);
    rd_chk("R5 value reset", 8'd6, 8'h00);
    rd_chk("R5 upper reset", 8'd16, 8'hFF);
    rd_chk("R5 lower reset", 8'd33, 8'h00);

    for (int i = 0; i < 17; i++) begin
      do_op(VEC[i].op, VEC[i].addr, VEC[i].data);
      if (VEC[i].op == 2'd1)
        check($sformatf("vec %0d read", i), {24'h0, reg_rdata}, {16'h0, VEC[i].exp});
      else if (VEC[i].op == 2'd2) begin
        check($sformatf("vec %0d upper event", i), {24'h0, alarm_hi},
              {24'h0, 8'(VEC[i].exp[0]) << VEC[i].addr});
        check($sformatf("vec %0d lower event", i), {24'h0, alarm_lo},
              {24'h0, 8'(VEC[i].exp[1]) << VEC[i].addr});
      end
    end

    // R3 snapshot: new sample lands between high and low byte reads
    do_op(2'd2, 8'd3, 16'hABCD);
    rd_chk("R3 high byte", 8'd6, 8'hAB);
    do_op(2'd2, 8'd3, 16'h1177);
    rd_chk("R3 low byte from snapshot", 8'd7, 8'hCD);
    rd_chk("R2 new high byte", 8'd6, 8'h11);
    rd_chk("R2 new low byte", 8'd7, 8'h77);

    // R10 data held with no read
    do_op(2'd2, 8'd3, 16'h2288);
    check("R10 rdata held", {24'h0, reg_rdata}, 32'h77);

    // R9 writes to value region and out of range ignored
    do_op(2'd0, 8'd6, 16'h0055);
    do_op(2'd0, 8'd50, 16'h0055);
    rd_chk("R9 value unchanged", 8'd6, 8'h22);
    rd_chk("R9 out of range read", 8'd50, 8'h00);
    rd_chk("R9 upper item0 unchanged", 8'd16, 8'hFF);

    // R8 data available after every item sampled (so far 0,2,3,5)
    do_op(2'd2, 8'd1, 16'h0010);
    do_op(2'd2, 8'd4, 16'h0010);
    do_op(2'd2, 8'd6, 16'h0010);
    @(negedge clk);
    check("R8 avail low with item 7 missing", {31'h0, data_avail}, 32'h0);
    do_op(2'd2, 8'd7, 16'h0010);
    @(negedge clk);
    check("R8 avail high", {31'h0, data_avail}, 32'h1);
    repeat (5) @(negedge clk);
    check("R8 avail sticky", {31'h0, data_avail}, 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule